// File: doc/BRIEF.md
# PLL Clock Mode Controller

This block chooses the clock that drives the CPU of a small controller that has a 32.768 kHz crystal and one on-chip PLL. Software reaches two byte-wide control registers through a write/read port. The block turns them into a multiplier code for the PLL and an enable request for it. It also produces the resulting CPU and audio-processor clock rates, which come from two separate divider paths fed by the one PLL.

When the PLL is switched on, a settle timer starts. It counts ticks of the slow crystal domain, and until it expires the CPU may not be moved onto the PLL. If software asks for PLL mode too early, the request is held as pending. The CPU changes source only on a slow-clock tick, so that an external glitch-free multiplexer always switches on a safe boundary.

While the CPU runs from the PLL with the audio processor enabled, the ratio fields are frozen. A write that tries to change them is dropped and raises a sticky error flag. There is no data stream here: every pin is a plain control or status level, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `pll_clock_ctrl`

Register 1 (`sel=1`), from bit 7 down to bit 0: `mult[1:0]`, `aud_half`, `aud_on`, `pll_on`, `cpu_div[1:0]`, `lxt_sel`.
Register 0 (`sel=0`) is read as `{err, pending, ready, 4'b0, ls_mode}`. On a write, bit 0 is taken as `ls_mode` and a 1 in bit 7 clears `err`.

Rates are given in units of 4.096 kHz, so the low-speed clock reads as 8.

## Requirements
- R1: After reset, register 1 reads 0x26 and register 0 reads 0x01. The CPU is on the low-speed clock, both rates read 8, and the PLL enable output is 0.
- R2: While `pll_on`=1, the audio rate is the PLL rate shifted right by `aud_half` (0 gives ÷1, 1 gives ÷2). The PLL rate for `mult` = 0, 1, 2 and 3 is 2000, 2500, 3000 and 4000 (8.192, 10.24, 12.288 and 16.384 MHz).
- R3: While the CPU is on the PLL, the CPU rate is the PLL rate divided by 1 for `cpu_div`=01, by 2 for 10, and by 4 for 11 and 00.
- R4: While `pll_on`=0, both rates read 8 regardless of the divider fields.
- R5: The ready bit (register 0, bit 5) sets on exactly the 328th tick sampled after `pll_on` becomes 1. It clears in the cycle after `pll_on` returns to 0, and the count starts again from zero on the next enable.
- R6: The pending bit (register 0, bit 6) is 1 while `ls_mode`=0 and the CPU is not yet on the PLL. The CPU moves to the PLL on the first tick edge at which ready is already 1.
- R7: With `ls_mode`=1, the CPU returns to the low-speed clock on the next tick edge. With `pll_on`=0, it leaves the PLL on the next clock edge without waiting for a tick.
- R8: While the CPU is on the PLL and `aud_on`=1, a register-1 write keeps `mult`, `aud_half` and `cpu_div` unchanged, and sets `err` if it tried to change any of them. Its other bits take effect. `err` is cleared only by writing register 0 with bit 7 set.
- R9: `idle_req_o` is the AND of `halt_req` and `lxt_sel`.
- R10: `pll_en_o`, `aud_en_o` and `pll_mult_o` follow `pll_on`, `aud_on` and `mult` in register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low reset |
| lf_tick | input | 1 | One-cycle pulse per 32.768 kHz period |
| wr_en | input | 1 | Register write strobe |
| sel | input | 1 | Register select: 0 for register 0, 1 for register 1 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| halt_req | input | 1 | Halt request from the CPU |
| pll_en_o | output | 1 | PLL enable request |
| pll_mult_o | output | 2 | PLL multiplier code |
| aud_en_o | output | 1 | Audio processor enable |
| cpu_on_pll_o | output | 1 | 1 when the CPU clock source is the PLL |
| cpu_rate_o | output | 16 | CPU clock rate in units of 4.096 kHz |
| aud_rate_o | output | 16 | Audio clock rate in units of 4.096 kHz |
| idle_req_o | output | 1 | Idle-mode entry request |

## Verification
Register contents, read-back, the enable and multiplier outputs and both rates change at the first rising edge that samples a write. The source change happens at the tick edge that R6 and R7 name, or one edge after a PLL disable. The bench drives inputs just after each rising edge and updates a behavioural model on the same edges. It compares every output against that model at each falling edge, so every result is checked in the cycle it is due and never a cycle late. Directed checks count the sampled tick edges between an enable and the rise of ready (328) and the source switch (329). They also count the single cycle before a disable takes the CPU off the PLL.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 16;
  localparam logic [DATA_W-1:0] CTL2_RST  = 8'h26;
  localparam logic [DATA_W-1:0] LOCK_MASK = 8'hE6;
  localparam logic [RATE_W-1:0] LS_RATE   = 16'd8;

  typedef struct packed {
    logic [1:0] mult;
    logic       aud_half;
    logic       aud_on;
    logic       pll_on;
    logic [1:0] cpu_div;
    logic       lxt_sel;
  } ctl2_t;

  function automatic logic [RATE_W-1:0] pll_rate(input logic [1:0] m);
    case (m)
      2'd0:    return 16'd2000;
      2'd1:    return 16'd2500;
      2'd2:    return 16'd3000;
      default: return 16'd4000;
    endcase
  endfunction

  function automatic logic [1:0] cpu_shift(input logic [1:0] d);
    case (d)
      2'b01:   return 2'd0;
      2'b10:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/clkctl_regs.sv
module clkctl_regs
  import clkctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cpu_on_pll,
  input  logic              ready,
  output ctl2_t             ctl2,
  output logic              ls_mode,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] ctl2_q;
  logic              mode_q;
  logic              err_q;
  logic              locked;
  logic              pending;

  assign ctl2    = ctl2_t'(ctl2_q);
  assign ls_mode = mode_q;
  assign locked  = cpu_on_pll & ctl2.aud_on;
  assign pending = ~mode_q & ~cpu_on_pll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl2_q <= CTL2_RST;
      mode_q <= 1'b1;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      if (sel) begin
        if (locked) begin
          ctl2_q <= (ctl2_q & LOCK_MASK) | (wdata & ~LOCK_MASK);
          if (((wdata ^ ctl2_q) & LOCK_MASK) != '0) err_q <= 1'b1;
        end else begin
          ctl2_q <= wdata;
        end
      end else begin
        mode_q <= wdata[0];
        if (wdata[DATA_W-1]) err_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (sel) rdata = ctl2_q;
    else     rdata = {err_q, pending, ready, 4'b0000, mode_q};
  end

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && locked) |=> ($stable(ctl2.mult) && $stable(ctl2.aud_half) && $stable(ctl2.cpu_div)));

  // R8
  lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && locked && (wdata[7:6] != ctl2.mult)) |=> rdata[7] || sel);
endmodule

// File: rtl/clkctl_settle.sv
module clkctl_settle #(
  parameter int SETTLE_TICKS = 328,
  localparam int CNT_W = $clog2(SETTLE_TICKS)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_on,
  input  logic tick,
  output logic ready
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (!pll_on) begin
      cnt_q <= '0;
      ready <= 1'b0;
    end else if (tick && !ready) begin
      if (cnt_q == CNT_W'(SETTLE_TICKS - 1)) begin
        cnt_q <= '0;
        ready <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5
  ready_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |=> !ready);

  // R5
  ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(tick));
endmodule

// File: rtl/clkctl_switch.sv
module clkctl_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pll_on,
  input  logic ready,
  input  logic ls_mode,
  output logic cpu_on_pll
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cpu_on_pll <= 1'b0;
    else if (!pll_on)           cpu_on_pll <= 1'b0;
    else if (tick) begin
      if (!ls_mode && ready)    cpu_on_pll <= 1'b1;
      else if (ls_mode)         cpu_on_pll <= 1'b0;
    end
  end

  // R6
  to_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_on_pll) |-> ($past(ready) && $past(tick)));

  // R7
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_on |=> !cpu_on_pll);

  // R7
  to_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_on_pll) |-> ($past(tick) || !$past(pll_on)));
endmodule

// File: rtl/clkctl_rates.sv
module clkctl_rates
  import clkctl_pkg::*;
(
  input  ctl2_t             ctl2,
  input  logic              cpu_on_pll,
  output logic [RATE_W-1:0] cpu_rate,
  output logic [RATE_W-1:0] aud_rate
);
  logic [RATE_W-1:0] base;

  always_comb begin
    base = pll_rate(ctl2.mult);
    if (cpu_on_pll) cpu_rate = base >> cpu_shift(ctl2.cpu_div);
    else            cpu_rate = LS_RATE;
    if (ctl2.pll_on) aud_rate = base >> ctl2.aud_half;
    else             aud_rate = LS_RATE;
  end
endmodule

// File: rtl/pll_clock_ctrl.sv
module pll_clock_ctrl
  import clkctl_pkg::*;
#(
  parameter int SETTLE_TICKS = 328
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        lf_tick,
  input  logic        wr_en,
  input  logic        sel,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        halt_req,
  output logic        pll_en_o,
  output logic [1:0]  pll_mult_o,
  output logic        aud_en_o,
  output logic        cpu_on_pll_o,
  output logic [15:0] cpu_rate_o,
  output logic [15:0] aud_rate_o,
  output logic        idle_req_o
);
  ctl2_t ctl2;
  logic  ls_mode;
  logic  ready;
  logic  on_pll;

  clkctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .cpu_on_pll(on_pll), .ready(ready), .ctl2(ctl2), .ls_mode(ls_mode), .rdata(rdata)
  );

  clkctl_settle #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_n), .pll_on(ctl2.pll_on), .tick(lf_tick), .ready(ready)
  );

  clkctl_switch u_switch (
    .clk(clk), .rst_n(rst_n), .tick(lf_tick), .pll_on(ctl2.pll_on),
    .ready(ready), .ls_mode(ls_mode), .cpu_on_pll(on_pll)
  );

  clkctl_rates u_rates (
    .ctl2(ctl2), .cpu_on_pll(on_pll), .cpu_rate(cpu_rate_o), .aud_rate(aud_rate_o)
  );

  assign pll_en_o     = ctl2.pll_on;
  assign pll_mult_o   = ctl2.mult;
  assign aud_en_o     = ctl2.aud_on;
  assign cpu_on_pll_o = on_pll;
  assign idle_req_o   = halt_req & ctl2.lxt_sel;
endmodule

// File: tb/pll_clock_ctrl_tb_top.sv
module pll_clock_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lf_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        sel = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic        halt_req = 1'b0;
  logic [7:0]  rdata;
  logic        pll_en_o, aud_en_o, cpu_on_pll_o, idle_req_o;
  logic [1:0]  pll_mult_o;
  logic [15:0] cpu_rate_o, aud_rate_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  int tick_edges = 0;

  // behavioural reference state
  int m_c2 = 'h26;
  int m_mode = 1;
  int m_err = 0;
  int m_cnt = 0;
  int m_ready = 0;
  int m_onpll = 0;

  always #5 clk = ~clk;

  pll_clock_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .lf_tick(lf_tick), .wr_en(wr_en), .sel(sel),
    .wdata(wdata), .rdata(rdata), .halt_req(halt_req), .pll_en_o(pll_en_o),
    .pll_mult_o(pll_mult_o), .aud_en_o(aud_en_o), .cpu_on_pll_o(cpu_on_pll_o),
    .cpu_rate_o(cpu_rate_o), .aud_rate_o(aud_rate_o), .idle_req_o(idle_req_o)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", req, got, exp, $time);
    end
  endtask

  function automatic int rate_of(input int m);
    int r [4] = '{2000, 2500, 3000, 4000};
    return r[m & 3];
  endfunction

  function automatic int cpu_div_of(input int d);
    if (d == 1) return 1;
    if (d == 2) return 2;
    return 4;
  endfunction

  // slow-domain tick: one pulse every 4 cycles, driven after the edge
  always @(posedge clk) begin
    #2;
    lf_tick = (($time / 10) % 4 == 0);
  end

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    int n_c2, n_mode, n_err, n_cnt, n_ready, n_onpll;
    int pen;
    if (!rst_n) begin
      m_c2 = 'h26; m_mode = 1; m_err = 0; m_cnt = 0; m_ready = 0; m_onpll = 0;
    end else begin
      if (lf_tick) tick_edges++;
      pen = (m_c2 >> 3) & 1;
      n_c2 = m_c2; n_mode = m_mode; n_err = m_err;
      n_cnt = m_cnt; n_ready = m_ready; n_onpll = m_onpll;
      if (pen == 0) begin
        n_cnt = 0; n_ready = 0; n_onpll = 0;
      end else if (lf_tick) begin
        if (m_ready == 0) begin
          if (m_cnt == 327) begin n_ready = 1; n_cnt = 0; end
          else n_cnt = m_cnt + 1;
        end
        if (m_mode == 0 && m_ready == 1) n_onpll = 1;
        else if (m_mode == 1) n_onpll = 0;
      end
      if (wr_en) begin
        if (sel) begin
          if (m_onpll == 1 && ((m_c2 >> 4) & 1) == 1) begin
            if (((int'(wdata) ^ m_c2) & 'hE6) != 0) n_err = 1;
            n_c2 = (m_c2 & 'hE6) | (int'(wdata) & 'h19);
          end else n_c2 = int'(wdata);
        end else begin
          n_mode = wdata[0];
          if (wdata[7]) n_err = 0;
        end
      end
      m_c2 = n_c2; m_mode = n_mode; m_err = n_err;
      m_cnt = n_cnt; m_ready = n_ready; m_onpll = n_onpll;
    end
  end

  // full comparison on every falling edge
  always @(negedge clk) begin
    int e_cpu, e_aud, e_rd;
    if (rst_n && cmp_on) begin
      e_cpu = m_onpll ? rate_of(m_c2 >> 6) / cpu_div_of((m_c2 >> 1) & 3) : 8;
      e_aud = ((m_c2 >> 3) & 1) ? rate_of(m_c2 >> 6) / (((m_c2 >> 5) & 1) + 1) : 8;
      e_rd  = sel ? m_c2 : ((m_err << 7) | (((m_mode == 0 && m_onpll == 0) ? 1 : 0) << 6)
                            | (m_ready << 5) | m_mode);
      chk("R3", cpu_rate_o, e_cpu);
      chk("R2", aud_rate_o, e_aud);
      chk("R6", cpu_on_pll_o, m_onpll);
      chk("R8", rdata, e_rd);
      chk("R9", idle_req_o, halt_req & m_c2 & 1);
      chk("R10", {pll_en_o, aud_en_o, pll_mult_o}, {((m_c2 >> 3) & 1) != 0, ((m_c2 >> 4) & 1) != 0, 2'(m_c2 >> 6)});
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; sel = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0; sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic a);
    @(posedge clk); #2;
    sel = a;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int snap;
    bit seen;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", rdata, 'h01);
    chk("R1", cpu_rate_o, 8);
    chk("R1", aud_rate_o, 8);
    chk("R1", pll_en_o, 0);
    chk("R1", cpu_on_pll_o, 0);
    rd(1'b1);
    chk("R1", rdata, 'h26);
    cmp_on = 1'b1;

    // R4: dividers set, PLL off
    wr(1'b1, 8'hC2);
    chk("R4", cpu_rate_o, 8);
    chk("R4", aud_rate_o, 8);

    // enable PLL: mult=10, aud ÷1, cpu ÷1
    wr(1'b1, 8'h8A);
    snap = tick_edges;
    chk("R2", aud_rate_o, 3000);
    chk("R10", pll_en_o, 1);
    wr(1'b0, 8'h00);
    rd(1'b0);
    chk("R6", rdata[6], 1);
    chk("R6", cpu_rate_o, 8);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (rdata[5]) begin
        seen = 1'b1;
        chk("R5", tick_edges - snap, 328);
        chk("R6", cpu_on_pll_o, 0);
      end
    end
    chk("R5", seen, 1);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (cpu_on_pll_o) begin
        seen = 1'b1;
        chk("R6", tick_edges - snap, 329);
      end
    end
    chk("R6", seen, 1);
    chk("R3", cpu_rate_o, 3000);

    // R3 dividers
    wr(1'b1, 8'h8C); chk("R3", cpu_rate_o, 1500);
    wr(1'b1, 8'h8E); chk("R3", cpu_rate_o, 750);
    wr(1'b1, 8'h88); chk("R3", cpu_rate_o, 750);
    // R2 multipliers
    wr(1'b1, 8'hCA); chk("R2", aud_rate_o, 4000); chk("R3", cpu_rate_o, 4000);
    wr(1'b1, 8'hEA); chk("R2", aud_rate_o, 2000);
    wr(1'b1, 8'h4A); chk("R2", aud_rate_o, 2500);
    wr(1'b1, 8'h0A); chk("R2", aud_rate_o, 2000);

    // R8 lock
    wr(1'b1, 8'h1A);
    wr(1'b1, 8'hDA);
    chk("R8", pll_mult_o, 0);
    chk("R8", cpu_rate_o, 2000);
    rd(1'b0);
    chk("R8", rdata[7], 1);
    wr(1'b1, 8'h1B);
    rd(1'b1);
    chk("R8", rdata, 'h1B);
    // R9 idle request
    @(posedge clk); #2 halt_req = 1'b1;
    @(negedge clk); chk("R9", idle_req_o, 1);
    wr(1'b1, 8'h1A);
    chk("R9", idle_req_o, 0);
    @(posedge clk); #2 halt_req = 1'b0;
    wr(1'b0, 8'h80);
    rd(1'b0);
    chk("R8", rdata[7], 0);

    // R7 back to low speed on a tick
    wr(1'b0, 8'h01);
    seen = 1'b0;
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk);
      if (!cpu_on_pll_o) seen = 1'b1;
    end
    chk("R7", seen, 1);
    chk("R7", cpu_rate_o, 8);
    wr(1'b0, 8'h00);
    repeat (10) @(negedge clk);
    chk("R6", cpu_on_pll_o, 1);

    // R7 disable drops source after one edge
    wr(1'b1, 8'h12);
    chk("R7", cpu_on_pll_o, 1);
    @(negedge clk);
    chk("R7", cpu_on_pll_o, 0);
    chk("R4", aud_rate_o, 8);
    chk("R5", rdata[5], 0);

    // R5 restart
    wr(1'b1, 8'h1A);
    repeat (400) @(negedge clk);
    rd(1'b0);
    chk("R5", rdata[5], 0);
    chk("R6", rdata[6], 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule